// File: doc/BRIEF.md
# Grouped BCD-to-Binary Converter

This block turns an unsigned packed BCD operand of `NUM_DIGITS` digits into its plain binary value. Digit i sits in bits [4i+3:4i]. The operand is cut into fixed-size slices of `GROUP_BITS` bits (4, 6 or 8), starting at bit 0 and moving upward. Each slice gets its own contribution generator.

A generator first rebuilds the slice's decimal value from the digit pieces inside it. It then scales that value by the power of ten of the slice's lowest digit. Every scaling by a constant is done with shifted copies of the operand that are added together, so no multiplier is used. A final adder combines all slice contributions.

`REG_OUT` picks between two output modes:
- a purely combinational path;
- one output register stage, which keeps its last result while no new operand arrives.

Top module: `bcd_bin_conv`

## Requirements
- R1: When `vld_i` is high and every digit of `bcd_i` is 0..9, the result equals the sum of digit_i × 10^i, with digit i taken from `bcd_i[4i+3:4i]`.
- R2: `bin_o` is floor(log2(10^N − 1)) + 1 bits wide. For the default N = 8 that is 27 bits, and an operand of all nines gives 99999999.
- R3: A valid result never exceeds 10^N − 1. Its remainder modulo 10 equals the least significant input digit. Its quotient by 10^(N−1) equals the most significant input digit.
- R4: `GROUP_BITS` = 4, 6 and 8 give bit-identical results for every valid operand. This includes a short top slice: 8-bit slices with an odd digit count, and the 2-bit leftover of 6-bit slices.
- R5: With `REG_OUT` = 1, `vld_o` and the result appear on the first rising clock edge after `vld_i` is sampled high. `vld_o` is low after any edge where `vld_i` was low.
- R6: With `REG_OUT` = 1, `bin_o` keeps its previous value while `vld_i` is low, whatever `bcd_i` carries.
- R7: While `rst_n` is low (asynchronous, active low), `vld_o` is 0 and `bin_o` is 0.
- R8: With `REG_OUT` = 0, `vld_o` follows `vld_i` and `bin_o` shows the converted `bcd_i` in the same cycle.
- R9: The operand 0x76 (digits 7 and 6, all others 0) converts to binary 1001100, which is 76.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | Operand on `bcd_i` is valid this cycle |
| bcd_i | input | 4*NUM_DIGITS | Packed BCD operand, digit 0 in the low nibble |
| vld_o | output | 1 | Result on `bin_o` is valid |
| bin_o | output | OUT_W | Unsigned binary result |

## Verification
The assertions assume that every nibble of `bcd_i` lies in 0..9 in each cycle where `vld_i` is high. Under that assumption the range, modulo-10 and leading-digit relations of R3 follow; an invalid nibble would break them.

The stimulus builds every operand one digit at a time from 0..9. This holds for random operands, single-digit operands, all zeros and all nines. While `vld_i` is low, the stimulus still puts changing valid digits on `bcd_i`, so the hold behaviour of R6 is exercised against a moving input without leaving the assumed domain.

// File: rtl/bcd_bin_pkg.sv
package bcd_bin_pkg;

    // 10^n as a 64-bit constant; n up to 19
    function automatic logic [63:0] pow10(input int n);
        logic [63:0] r;
        r = 64'd1;
        for (int k = 0; k < n; k++) r = (r << 3) + (r << 1);
        return r;
    endfunction

    // bits needed to hold 10^n - 1
    function automatic int bin_width(input int n);
        logic [63:0] v;
        int w;
        v = pow10(n) - 64'd1;
        w = 0;
        for (int k = 0; k < 64; k++) if (v[k]) w = k + 1;
        return w;
    endfunction

    // product with a constant, formed as a sum of shifted copies of v
    function automatic logic [63:0] shift_add_mul(input logic [63:0] v, input logic [63:0] c);
        logic [63:0] r;
        r = '0;
        for (int k = 0; k < 64; k++) if (c[k]) r = r + (v << k);
        return r;
    endfunction

    typedef struct packed {
        logic        vld;
        logic [63:0] bin;
    } out_st_t;

endpackage

// File: rtl/bcd_grp_contrib.sv
module bcd_grp_contrib
    import bcd_bin_pkg::*;
#(
    parameter int OUT_W = 27,
    parameter int LSB   = 0,
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] grp_i,
    output logic [OUT_W-1:0] contrib_o
);
    localparam int BASE_D = LSB / 4;
    localparam int TOP_D  = (LSB + WIDTH - 1) / 4;

    logic [63:0] grp_val_d;
    logic [63:0] contrib_d;

    // rebuild the slice's decimal value from its digit pieces
    always_comb begin
        grp_val_d = '0;
        for (int d = BASE_D; d <= TOP_D; d++) begin
            int lo;
            int hi;
            logic [63:0] piece;
            lo    = (LSB > 4 * d) ? LSB : 4 * d;
            hi    = (LSB + WIDTH - 1 < 4 * d + 3) ? LSB + WIDTH - 1 : 4 * d + 3;
            piece = (64'(grp_i) >> (lo - LSB)) & ((64'd1 << (hi - lo + 1)) - 64'd1);
            piece = piece << (lo - 4 * d);
            grp_val_d = grp_val_d + shift_add_mul(piece, pow10(d - BASE_D));
        end
        contrib_d = shift_add_mul(grp_val_d, pow10(BASE_D));
    end

    assign contrib_o = contrib_d[OUT_W-1:0];
endmodule

// File: rtl/bcd_contrib_sum.sv
module bcd_contrib_sum #(
    parameter int OUT_W  = 27,
    parameter int NGROUP = 8
) (
    input  logic [NGROUP*OUT_W-1:0] contrib_i,
    output logic [OUT_W-1:0]        sum_o
);
    always_comb begin
        sum_o = '0;
        for (int g = 0; g < NGROUP; g++) sum_o = sum_o + contrib_i[g*OUT_W +: OUT_W];
    end
endmodule

// File: rtl/bcd_bin_conv.sv
module bcd_bin_conv
    import bcd_bin_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter int GROUP_BITS = 4,
    parameter bit REG_OUT    = 1'b1,
    localparam int IN_W      = 4 * NUM_DIGITS,
    localparam int OUT_W     = bin_width(NUM_DIGITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [IN_W-1:0]  bcd_i,
    output logic             vld_o,
    output logic [OUT_W-1:0] bin_o
);
    localparam int NGROUP = (IN_W + GROUP_BITS - 1) / GROUP_BITS;

    logic [NGROUP*OUT_W-1:0] contrib;
    logic [OUT_W-1:0]        sum;

    for (genvar g = 0; g < NGROUP; g++) begin : g_slice
        localparam int SL_LSB = g * GROUP_BITS;
        localparam int SL_W   = (IN_W - SL_LSB < GROUP_BITS) ? IN_W - SL_LSB : GROUP_BITS;
        bcd_grp_contrib #(
            .OUT_W(OUT_W),
            .LSB  (SL_LSB),
            .WIDTH(SL_W)
        ) u_contrib (
            .grp_i    (bcd_i[SL_LSB +: SL_W]),
            .contrib_o(contrib[g*OUT_W +: OUT_W])
        );
    end

    bcd_contrib_sum #(
        .OUT_W (OUT_W),
        .NGROUP(NGROUP)
    ) u_sum (
        .contrib_i(contrib),
        .sum_o    (sum)
    );

    out_st_t st_d;
    out_st_t st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) st_d.bin = 64'(sum);
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= st_d;
        end
        assign vld_o = st_q.vld;
        assign bin_o = st_q.bin[OUT_W-1:0];
    end else begin : g_comb
        assign st_q  = '0;
        assign vld_o = vld_i;
        assign bin_o = sum;
    end
endmodule

// File: rtl/bcd_bin_conv_chk.sv
module bcd_bin_conv_chk
    import bcd_bin_pkg::*;
#(
    parameter int NUM_DIGITS = 8,
    parameter bit REG_OUT    = 1'b1,
    localparam int IN_W      = 4 * NUM_DIGITS,
    localparam int OUT_W     = bin_width(NUM_DIGITS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vld_i,
    input logic [IN_W-1:0]  bcd_i,
    input logic             vld_o,
    input logic [OUT_W-1:0] bin_o
);
    localparam logic [63:0] MAXV = pow10(NUM_DIGITS) - 64'd1;
    localparam logic [63:0] TOPW = pow10(NUM_DIGITS - 1);

    if (REG_OUT) begin : g_reg_chk
        p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> vld_o);
        p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_i |=> !vld_o);
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_i |=> $stable(bin_o));
        p_lsd_r3: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> (64'(bin_o) % 64'd10) == 64'($past(bcd_i[3:0])));
        p_msd_r3: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |=> (64'(bin_o) / TOPW) == 64'($past(bcd_i[IN_W-1:IN_W-4])));
        p_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (vld_i && bcd_i == '0) |=> bin_o == '0);
    end else begin : g_comb_chk
        p_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
            vld_o == vld_i);
        p_lsd_r3: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |-> (64'(bin_o) % 64'd10) == 64'(bcd_i[3:0]));
        p_msd_r3: assert property (@(posedge clk) disable iff (!rst_n)
            vld_i |-> (64'(bin_o) / TOPW) == 64'(bcd_i[IN_W-1:IN_W-4]));
    end

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o |-> 64'(bin_o) <= MAXV);
endmodule

bind bcd_bin_conv bcd_bin_conv_chk #(
    .NUM_DIGITS(NUM_DIGITS),
    .REG_OUT   (REG_OUT)
) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .vld_i(vld_i),
    .bcd_i(bcd_i),
    .vld_o(vld_o),
    .bin_o(bin_o)
);

// File: tb/bcd_bin_conv_test.sv
module bcd_bin_conv_test;
    localparam int CLK_PERIOD = 10;
    localparam int ND = 8;
    localparam int OW = 27;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [31:0] bcd = '0;

    logic          vld4, vld6, vld8, vldc, vldo;
    logic [OW-1:0] bin4, bin6, bin8, binc;
    logic [23:0]   bino;

    int compared = 0;
    int mismatched = 0;
    bit mon_on = 1'b0;
    longint unsigned exp_q[$];
    longint unsigned last_exp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bcd_bin_conv #(.NUM_DIGITS(ND), .GROUP_BITS(4), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .bcd_i(bcd), .vld_o(vld4), .bin_o(bin4));
    bcd_bin_conv #(.NUM_DIGITS(ND), .GROUP_BITS(6), .REG_OUT(1'b1)) uut_g6 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .bcd_i(bcd), .vld_o(vld6), .bin_o(bin6));
    bcd_bin_conv #(.NUM_DIGITS(ND), .GROUP_BITS(8), .REG_OUT(1'b1)) uut_g8 (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .bcd_i(bcd), .vld_o(vld8), .bin_o(bin8));
    bcd_bin_conv #(.NUM_DIGITS(ND), .GROUP_BITS(6), .REG_OUT(1'b0)) uut_comb (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .bcd_i(bcd), .vld_o(vldc), .bin_o(binc));
    bcd_bin_conv #(.NUM_DIGITS(7), .GROUP_BITS(8), .REG_OUT(1'b0)) uut_odd (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .bcd_i(bcd[27:0]), .vld_o(vldo), .bin_o(bino));

    function automatic longint unsigned ref_val(input logic [31:0] v, input int n);
        longint unsigned acc = 0;
        longint unsigned w = 1;
        for (int i = 0; i < n; i++) begin
            acc += longint'(v[4*i +: 4]) * w;
            w *= 10;
        end
        return acc;
    endfunction

    function automatic logic [31:0] rand_bcd();
        logic [31:0] v;
        for (int i = 0; i < ND; i++) v[4*i +: 4] = 4'($urandom_range(0, 9));
        return v;
    endfunction

    task automatic check(input string req, input longint unsigned act, input longint unsigned expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic send(input logic [31:0] v);
        longint unsigned e;
        @(negedge clk);
        vld_i = 1'b1;
        bcd   = v;
        e     = ref_val(v, ND);
        #1;
        check("R8 comb valid", longint'(vldc), 1);
        check("R8 comb result same cycle (R4 6-bit)", longint'(binc), e);
        check("R4 odd digit count 8-bit slices", longint'(bino), ref_val(v, 7));
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            vld_i = 1'b0;
            bcd   = rand_bcd();
            #1;
            check("R8 comb valid low", longint'(vldc), 0);
        end
    endtask

    // monitor: pops expected results as the registered instances deliver them
    always @(negedge clk) begin
        if (mon_on) begin
            if (vld4) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected valid", 1, 0);
                end else begin
                    longint unsigned e;
                    e = exp_q.pop_front();
                    check("R1 4-bit result", longint'(bin4), e);
                    check("R4 6-bit result", longint'(bin6), e);
                    check("R4 8-bit result", longint'(bin8), e);
                    check("R5 valid aligned", longint'({vld6, vld8}), 3);
                    last_exp = e;
                end
            end else begin
                check("R5 valid low", longint'({vld6, vld8}), 0);
                check("R6 hold 4-bit", longint'(bin4), last_exp);
                check("R6 hold 8-bit", longint'(bin8), last_exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        vld_i = 1'b0;
        bcd   = 32'h9999_9999;
        repeat (3) @(negedge clk);
        check("R7 reset valid", longint'(vld4), 0);
        check("R7 reset result", longint'(bin4), 0);
        check("R7 reset result 6-bit", longint'(bin6), 0);
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;

        send(32'h0000_0076);                       // R9: expect 76
        send(32'h0000_0000);                       // R1 all zeros
        send(32'h9999_9999);                       // R2 all nines -> 99999999
        idle(2);
        for (int d = 0; d < ND; d++) begin
            send(32'h9 << (4 * d));
            send(32'h1 << (4 * d));
        end
        send(32'h1000_0001);
        idle(3);
        for (int k = 0; k < 300; k++) begin
            send(rand_bcd());
            if (k % 7 == 0) idle(1 + (k % 3));
        end
        idle(4);

        check("R9 worked example", ref_val(32'h76, ND), 64'b1001100);
        check("R5 all results delivered", longint'(exp_q.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule